// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the bus-facing slave of a small byte-addressed serial memory. It watches a two-wire bus (clock and data, both oversampled on the system clock) and answers two kinds of read. A current-address read uses an internal location pointer that persists between transactions. A random read starts with a short write-direction transfer that only loads the pointer, then a repeated start in the read direction. The slave drives the data line only through an open-drain pull-down enable. While the master acknowledges, it streams bytes from consecutive locations.

The storage is a 512-byte register array inside the block. A synchronous test write port fills it, and a write through that port also moves the pointer, the same way a bus access would. Bus-side writes of data bytes are not part of this block.

The controller has seven states. `ST_IDLE` ignores the bus until a start. `ST_DEV` shifts in the device byte. `ST_DEV_ACK` drives the acknowledge for a matching device byte. `ST_WORD` shifts in the word address. `ST_WORD_ACK` acknowledges the word address and then returns to idle to wait for a repeated start. `ST_TX` shifts a data byte out. `ST_TX_ACK` samples the master's acknowledge.

The transitions are these. A start from any state goes to `ST_DEV`, and a stop goes to `ST_IDLE`. `ST_DEV` goes to `ST_DEV_ACK` on a match and to `ST_IDLE` on a mismatch. `ST_DEV_ACK` goes to `ST_TX` for a read and to `ST_WORD` for a write. `ST_WORD` goes to `ST_WORD_ACK`, and `ST_WORD_ACK` goes to `ST_IDLE`. `ST_TX` goes to `ST_TX_ACK`. `ST_TX_ACK` goes back to `ST_TX` on an acknowledge and to `ST_IDLE` on a no-acknowledge.

Top module: `eeprom_rd_slave`

## Requirements
- R1: The device byte is sent MSB first and laid out as follows: bits 7..4 must equal 4'b1010, bits 3..2 must equal 2'b00, bit 1 is address bit 8, and bit 0 is the direction (1 = read). On a match the slave pulls the data line low for the ninth clock.
- R2: A device byte that does not match is not acknowledged. The slave then drives nothing and ignores all bus activity until the next start, and its location pointer is unchanged.
- R3: In the write direction, the slave acknowledges the next byte as the word address. It loads {device bit 1, word byte} into the pointer and writes nothing to memory.
- R4: A repeated start right after the word-address acknowledge, followed by a matching read-direction device byte, returns the byte at the word address just loaded.
- R5: A read-direction transfer with no address returns the byte at the pointer. The pointer advances by one after every byte sent, so after an access to location n the next current-address read returns location n+1.
- R6: A test write of data d to location n stores d there and sets the pointer to n+1.
- R7: When the master acknowledges a data byte, the slave sends the byte at the next location. The pointer wraps from 511 to 0.
- R8: When the master does not acknowledge a data byte, the slave releases the data line and stays released until a start.
- R9: The pull-down enable changes only while the sampled clock is low. It is 1 to drive a 0, and data bits go out MSB first.
- R10: A start seen in the middle of any byte aborts it, clears the bit count and begins device-byte reception.
- R11: After reset the slave is idle with the line released, and it does not acknowledge bytes clocked before the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| tst_wr_en | input | 1 | Test write strobe into the storage array |
| tst_wr_addr | input | 9 | Test write location |
| tst_wr_data | input | 8 | Test write data |

## Verification
Several properties are checked on every cycle. The pull-down enable only ever changes after a low sample of the bus clock. The acknowledge is held throughout the acknowledge clock of both address bytes. The line is released in idle, and the pointer steps by exactly one when a byte has been sent. Only the bench scenarios can show that the right bytes come back. Those scenarios cover swept random-read addresses, the wrap from 511 to 0, current-address reads after reads and after test writes, rejected device bytes leaving the pointer alone, and a start that aborts a half-received byte.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_TX,
        ST_TX_ACK
    } rd_state_e;

endpackage

// File: rtl/eeprom_line_mon.sv
// Oversamples the two bus lines and produces clock edges and start/stop events.
module eeprom_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    // Data edges with the clock held high on both samples mark bus conditions.
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/eeprom_store.sv
// Byte array with one synchronous write port and an asynchronous read port.
module eeprom_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eeprom_addr_ctr.sv
// Persistent location pointer: bus load, post-access step, test-write update.
module eeprom_addr_ctr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              tst_wr,
    input  logic [ADDR_W-1:0] tst_addr,
    output logic [ADDR_W-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr + ADDR_W'(1);
        end else if (tst_wr) begin
            ptr <= tst_addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave
    import eeprom_rd_pkg::*;
#(
    parameter int         ADDR_W      = 9,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010,
    parameter logic [2:0] DEV_SEL     = 3'b000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              tst_wr_en,
    input  logic [ADDR_W-1:0] tst_wr_addr,
    input  logic [7:0]        tst_wr_data
);

    // Location bits above the word byte come from the device byte (1..3 bits).
    localparam int HI_W = ADDR_W - 8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    eeprom_line_mon #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    rd_state_e         state_q, state_d;
    logic [3:0]        bitcnt_q, bitcnt_d;
    logic [7:0]        shreg_q, shreg_d;
    logic              rw_q, rw_d;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic              ack_hi_q, ack_hi_d;
    logic              oe_q, oe_d;
    logic              ptr_load, ptr_step;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        rd_data;
    logic [7:0]        rx_byte;
    logic              sel_ok;
    logic              dev_match;

    eeprom_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(8)
    ) u_store (
        .clk    (clk),
        .wr_en  (tst_wr_en),
        .wr_addr(tst_wr_addr),
        .wr_data(tst_wr_data),
        .rd_addr(ptr),
        .rd_data(rd_data)
    );

    eeprom_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val({hi_q, rx_byte}),
        .step    (ptr_step),
        .tst_wr  (tst_wr_en),
        .tst_addr(tst_wr_addr),
        .ptr     (ptr)
    );

    assign rx_byte = {shreg_q[6:0], sda_lvl};

    generate
        if (HI_W < 3) begin : g_sel
            assign sel_ok = (rx_byte[3:HI_W+1] == DEV_SEL[2:HI_W]);
        end else begin : g_nosel
            assign sel_ok = 1'b1;
        end
    endgenerate

    assign dev_match = (rx_byte[7:4] == DEV_PREFIX) && sel_ok;

    // Next-state and next-output logic.
    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        shreg_d  = shreg_q;
        rw_d     = rw_q;
        hi_d     = hi_q;
        ack_hi_d = ack_hi_q;
        oe_d     = oe_q;
        ptr_load = 1'b0;
        ptr_step = 1'b0;

        if (start_ev) begin
            state_d  = ST_DEV;
            bitcnt_d = '0;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (scl_fall) begin
                        oe_d = 1'b0;
                    end
                end
                ST_DEV: begin
                    if (scl_rise) begin
                        shreg_d  = rx_byte;
                        bitcnt_d = bitcnt_q + 4'd1;
                        if (bitcnt_q == 4'd7) begin
                            if (dev_match) begin
                                state_d  = ST_DEV_ACK;
                                rw_d     = rx_byte[0];
                                hi_d     = rx_byte[HI_W:1];
                                ack_hi_d = 1'b0;
                            end else begin
                                state_d = ST_IDLE;
                            end
                        end
                    end else if (scl_fall) begin
                        oe_d = 1'b0;
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_rise) begin
                        ack_hi_d = 1'b1;
                    end else if (scl_fall) begin
                        if (!ack_hi_q) begin
                            oe_d = 1'b1;
                        end else if (rw_q) begin
                            state_d  = ST_TX;
                            shreg_d  = rd_data;
                            oe_d     = ~rd_data[7];
                            bitcnt_d = '0;
                        end else begin
                            state_d  = ST_WORD;
                            oe_d     = 1'b0;
                            bitcnt_d = '0;
                        end
                    end
                end
                ST_WORD: begin
                    if (scl_rise) begin
                        shreg_d  = rx_byte;
                        bitcnt_d = bitcnt_q + 4'd1;
                        if (bitcnt_q == 4'd7) begin
                            ptr_load = 1'b1;
                            state_d  = ST_WORD_ACK;
                            ack_hi_d = 1'b0;
                        end
                    end else if (scl_fall) begin
                        oe_d = 1'b0;
                    end
                end
                ST_WORD_ACK: begin
                    if (scl_rise) begin
                        ack_hi_d = 1'b1;
                    end else if (scl_fall) begin
                        if (!ack_hi_q) begin
                            oe_d = 1'b1;
                        end else begin
                            oe_d    = 1'b0;
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt_d = bitcnt_q + 4'd1;
                        if (bitcnt_q == 4'd7) begin
                            state_d  = ST_TX_ACK;
                            ptr_step = 1'b1;
                            ack_hi_d = 1'b0;
                        end
                    end else if (scl_fall) begin
                        oe_d    = ~shreg_q[6];
                        shreg_d = {shreg_q[6:0], 1'b0};
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (!sda_lvl) begin
                            ack_hi_d = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else if (scl_fall) begin
                        if (!ack_hi_q) begin
                            oe_d = 1'b0;
                        end else begin
                            state_d  = ST_TX;
                            shreg_d  = rd_data;
                            oe_d     = ~rd_data[7];
                            bitcnt_d = '0;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            rw_q     <= 1'b0;
            hi_q     <= '0;
            ack_hi_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            shreg_q  <= shreg_d;
            rw_q     <= rw_d;
            hi_q     <= hi_d;
            ack_hi_q <= ack_hi_d;
            oe_q     <= oe_d;
        end
    end

    assign sda_oe = oe_q;

    // The pull-down may only move after a low sample of the bus clock.
    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !$past(scl_lvl));

    // Both address acknowledges are held low across the acknowledge clock.
    assert_ack_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DEV_ACK || state_q == ST_WORD_ACK) && ack_hi_q) |-> oe_q);

    // Idle never pulls the line.
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !oe_q);

    // A completed data byte moves the pointer by exactly one (with wrap).
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TX_ACK && $past(state_q) == ST_TX) |-> ptr == $past(ptr) + ADDR_W'(1));

    // Bit count never runs past one byte.
    assert_bitcnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= 4'd8);

endmodule

// File: tb/eeprom_rd_slave_test.sv
module eeprom_rd_slave_test;

    localparam int Q      = 6;
    localparam int ADDR_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              tst_wr_en = 1'b0;
    logic [ADDR_W-1:0] tst_wr_addr = '0;
    logic [7:0]        tst_wr_data = '0;
    logic              sda_oe;
    logic              line;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign line = sda_m & ~sda_oe;

    eeprom_rd_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (line),
        .sda_oe     (sda_oe),
        .tst_wr_en  (tst_wr_en),
        .tst_wr_addr(tst_wr_addr),
        .tst_wr_data(tst_wr_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29) + 7 + ((a >> 8) * 85));
    endfunction

    function automatic logic [7:0] dev_byte(input int a, input bit rd);
        return {4'b1010, 2'b00, 1'(a >> 8), rd};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic clk_bit(input bit v, output bit seen, output bit stab);
        bit s1, s2;
        sda_m = v; waitq();
        scl_m = 1'b1; waitq();
        s1 = line; waitq();
        s2 = line;
        scl_m = 1'b0; waitq();
        seen = s1;
        stab = (s1 == s2);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        bit s, st;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s, st);
        clk_bit(1'b1, s, st);
        ack = !s;
    endtask

    task automatic rd_byte(input bit master_ack, output logic [7:0] b, output bit stab_all);
        bit s, st;
        b = '0;
        stab_all = 1'b1;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s, st);
            b = {b[6:0], s};
            stab_all = stab_all & st;
        end
        clk_bit(!master_ack, s, st);
    endtask

    task automatic read_run(input int first, input int nbytes, input string req);
        logic [7:0] b;
        bit st;
        for (int i = 0; i < nbytes; i++) begin
            rd_byte(i < nbytes - 1, b, st);
            check(b == pat((first + i) % DEPTH), req, b, pat((first + i) % DEPTH));
            check(st, "R9 data stable while clock high", st, 1);
        end
        check(sda_oe == 1'b0 && line == 1'b1, "R8 released after no-ack", sda_oe, 0);
    endtask

    task automatic rand_read(input int a, input int nbytes, input string req);
        bit ack;
        bus_start();
        wr_byte(dev_byte(a, 1'b0), ack);
        check(ack, "R1 device ack (write dir)", ack, 1);
        wr_byte(8'(a), ack);
        check(ack, "R3 word address ack", ack, 1);
        bus_start();
        wr_byte(dev_byte(a, 1'b1), ack);
        check(ack, "R4 device ack after repeated start", ack, 1);
        read_run(a, nbytes, req);
        bus_stop();
    endtask

    task automatic cur_read(input int a, input int nbytes, input string req);
        bit ack;
        bus_start();
        wr_byte(dev_byte(0, 1'b1), ack);
        check(ack, "R1 device ack (read dir)", ack, 1);
        read_run(a, nbytes, req);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack, s, st;
        logic [7:0] b;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: released after reset; bytes before any start are ignored.
        check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);
        scl_m = 1'b0; waitq();
        wr_byte(8'hA1, ack);
        check(!ack, "R11 no ack before start", ack, 0);
        scl_m = 1'b1; waitq();

        // Fill the array through the test port.
        for (int a = 0; a < DEPTH; a++) begin
            tst_wr_en   = 1'b1;
            tst_wr_addr = ADDR_W'(a);
            tst_wr_data = pat(a);
            @(negedge clk);
        end
        tst_wr_en = 1'b0;
        @(negedge clk);

        // R6 and R7: last test write was to 511, so the pointer wrapped to 0.
        cur_read(0, 1, "R6 pointer after test write to 511");
        tst_wr_en = 1'b1; tst_wr_addr = 9'd100; tst_wr_data = pat(100);
        @(negedge clk);
        tst_wr_en = 1'b0;
        @(negedge clk);
        cur_read(101, 1, "R6 pointer after test write to 100");

        // R4 and R5: swept random reads, each followed by a current-address read.
        for (int k = 0; k < 20; k++) begin
            int a;
            a = (k * 53 + 5) % DEPTH;
            rand_read(a, 1, "R4 random read data");
            cur_read((a + 1) % DEPTH, 1, "R5 current read after access");
        end
        rand_read(255, 1, "R4 random read at 255");
        rand_read(256, 1, "R4 random read at 256 (bit 8 from device byte)");

        // R7: sequential stream across the top of the array.
        rand_read(508, 6, "R7 sequential read with wrap");
        cur_read(2, 1, "R7 pointer after wrapped stream");

        // R3: dummy write then stop loads the pointer without writing memory.
        bus_start();
        wr_byte(dev_byte(77, 1'b0), ack);
        check(ack, "R3 device ack", ack, 1);
        wr_byte(8'd77, ack);
        check(ack, "R3 word ack", ack, 1);
        bus_stop();
        cur_read(77, 2, "R3 pointer loaded, memory intact");

        // R2: mismatched device bytes are ignored and the pointer stays put.
        rand_read(40, 1, "R4 random read at 40");
        bus_start();
        wr_byte(8'hA9, ack);
        check(!ack, "R2 select-bit mismatch not acked", ack, 0);
        wr_byte(8'h33, ack);
        check(!ack, "R2 following byte ignored", ack, 0);
        check(sda_oe == 1'b0, "R2 line released while ignoring", sda_oe, 0);
        bus_stop();
        bus_start();
        wr_byte(8'hB1, ack);
        check(!ack, "R2 prefix mismatch not acked", ack, 0);
        bus_stop();
        cur_read(41, 1, "R2 pointer unchanged by rejected bytes");

        // R10: a start in the middle of a byte restarts reception.
        rand_read(200, 1, "R4 random read at 200");
        bus_start();
        clk_bit(1'b1, s, st);
        clk_bit(1'b0, s, st);
        clk_bit(1'b1, s, st);
        bus_start();
        wr_byte(dev_byte(0, 1'b1), ack);
        check(ack, "R10 ack after aborting start", ack, 1);
        read_run(201, 1, "R10 data after abort");
        bus_stop();

        // R8: after a no-ack the slave stays off the line for further clocks.
        bus_start();
        wr_byte(dev_byte(0, 1'b1), ack);
        check(ack, "R8 device ack", ack, 1);
        rd_byte(1'b0, b, st);
        check(b == pat(202), "R8 data before no-ack", b, pat(202));
        rd_byte(1'b0, b, st);
        check(b == 8'hFF, "R8 no drive after no-ack", b, 8'hFF);
        bus_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule